// File: doc/BRIEF.md
# Triadic Fused Cipher ALU

This functional unit executes two dependent integer operations in a single instruction. Each instruction supplies three 32-bit source values, `a`, `b` and `c`, and an 8-bit pair code. The first operation combines `a` with `b`. The second operation then combines that intermediate value with `c`. Both operations settle in the same cycle, and the final value is captured in a result register. Typical fused forms are add-then-xor `(a+b)^c`, and-then-rotate `(a&b) rotl c`, and rotate-by-a-constant followed by an xor with a third register.

Operations fall into two classes. The light class holds xor, and, increment, sign-extend and a pass-through. The arithmetic class holds add, subtract, rotate left, rotate right and a second pass-through. Three pairings are accepted: light then light, light then arithmetic, and arithmetic then light. Two arithmetic operations in one instruction, or any undefined operation code, form an illegal pair. An illegal pair is reported by an error pulse and leaves the result register untouched.

Top module: `tfa_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `out_err` are 0 and `out_result` is 0.
- R2: A legal instruction presented with `in_valid`=1 gives `out_valid`=1 and its result on `out_result` exactly one clock later, with `out_err`=0.
- R3: `in_op[7:4]` selects the first operation and `in_op[3:0]` selects the second operation. Light codes are 0 pass, 1 xor, 2 and, 3 increment and 4 sign-extend. Arithmetic codes are 8 pass, 9 add, 10 subtract, 11 rotate left and 12 rotate right. Codes 5, 6, 7, 13, 14 and 15 are undefined.
- R4: An instruction whose two codes are both arithmetic, or which contains an undefined code, raises `out_err` for exactly one cycle, one clock later, with `out_valid`=0.
- R5: `out_result` keeps its previous value after an illegal instruction and after any cycle with `in_valid`=0.
- R6: Light operations on (x,y) give x^y, x&y, x+1 and {24 copies of x[7], x[7:0]}. Pass gives x. Increment, sign-extend and pass do not depend on y.
- R7: Add and subtract give x+y and x-y modulo 2^32.
- R8: Rotate left and rotate right move x by y[4:0] positions. The upper bits of y have no effect.
- R9: The result equals op2(op1(a,b), c). The first operation's output feeds the second operation's x input.
- R10: A cycle with `in_valid`=0 gives `out_valid`=0 and `out_err`=0 one clock later, whatever `in_op` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 8 | Pair code: first operation [7:4], second operation [3:0] |
| in_a | input | 32 | Source operand 1 |
| in_b | input | 32 | Source operand 2 |
| in_c | input | 32 | Source operand 3 |
| out_valid | output | 1 | Registered result is new this cycle |
| out_result | output | 32 | Registered result |
| out_err | output | 1 | One-cycle illegal-pair pulse |

## Verification
If a stage selects the wrong operation or the chain is wired wrong, the result one cycle after the instruction is wrong. This shows up in the first random instruction that uses the affected code. A wrong legality decision appears on that same cycle as a swapped `out_valid`/`out_err` pair. If an illegal or idle cycle lets the result register load, the held value changes, and the bench compares it against the last legal result it expected. A rotate that uses more than five bits of its amount differs from the expected value whenever the random `c` or `b` has upper bits set.

// File: rtl/tfa_pkg.sv
package tfa_pkg;

  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_TPASS = 4'd0,
    OP_XOR   = 4'd1,
    OP_AND   = 4'd2,
    OP_INC   = 4'd3,
    OP_SEXT  = 4'd4,
    OP_SPASS = 4'd8,
    OP_ADD   = 4'd9,
    OP_SUB   = 4'd10,
    OP_ROL   = 4'd11,
    OP_ROR   = 4'd12
  } op_code_e;

  typedef enum logic [1:0] {
    CLS_LIGHT = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_BAD   = 2'd2
  } op_class_e;

  // class of a raw 4-bit code; undefined codes map to CLS_BAD
  function automatic op_class_e code_class(input logic [OPW-1:0] code);
    case (code)
      OP_TPASS, OP_XOR, OP_AND, OP_INC, OP_SEXT: code_class = CLS_LIGHT;
      OP_SPASS, OP_ADD, OP_SUB, OP_ROL, OP_ROR:  code_class = CLS_ARITH;
      default:                                  code_class = CLS_BAD;
    endcase
  endfunction

endpackage

// File: rtl/tfa_decode.sv
module tfa_decode
  import tfa_pkg::*;
#(
  parameter int unsigned CODEW = 8
) (
  input  logic [CODEW-1:0] pair_code,
  output logic [OPW-1:0]   first_code,
  output logic [OPW-1:0]   second_code,
  output logic             pair_legal
);
  localparam int unsigned HI = CODEW - 1;

  op_class_e cls_first;
  op_class_e cls_second;
  logic      any_bad;
  logic      both_arith;

  assign first_code  = pair_code[HI -: OPW];
  assign second_code = pair_code[OPW-1:0];

  always_comb begin
    cls_first  = code_class(first_code);
    cls_second = code_class(second_code);
    any_bad    = (cls_first == CLS_BAD) || (cls_second == CLS_BAD);
    both_arith = (cls_first == CLS_ARITH) && (cls_second == CLS_ARITH);
    pair_legal = !any_bad && !both_arith;
  end

endmodule

// File: rtl/tfa_opunit.sv
module tfa_opunit
  import tfa_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned SEXT_BIT = 7
) (
  input  logic [OPW-1:0] code,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [W-1:0]   z
);
  localparam int unsigned SHW = $clog2(W);

  function automatic logic [W-1:0] rot_left(input logic [W-1:0] v,
                                            input logic [SHW-1:0] s);
    rot_left = (v << s) | (v >> (W - int'(s)));
  endfunction

  function automatic logic [W-1:0] rot_right(input logic [W-1:0] v,
                                             input logic [SHW-1:0] s);
    rot_right = (v >> s) | (v << (W - int'(s)));
  endfunction

  function automatic logic [W-1:0] sign_ext(input logic [W-1:0] v);
    sign_ext = {{(W-SEXT_BIT-1){v[SEXT_BIT]}}, v[SEXT_BIT:0]};
  endfunction

  logic [SHW-1:0] amt;
  assign amt = y[SHW-1:0];

  always_comb begin
    case (code)
      OP_XOR:  z = x ^ y;
      OP_AND:  z = x & y;
      OP_INC:  z = x + {{(W-1){1'b0}}, 1'b1};
      OP_SEXT: z = sign_ext(x);
      OP_ADD:  z = x + y;
      OP_SUB:  z = x - y;
      OP_ROL:  z = rot_left(x, amt);
      OP_ROR:  z = rot_right(x, amt);
      default: z = x;
    endcase
  end

endmodule

// File: rtl/tfa_top.sv
module tfa_top
  import tfa_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_err
);
  localparam int unsigned CODEW = OPW * STAGES;

  logic [OPW-1:0] first_code;
  logic [OPW-1:0] second_code;
  logic           pair_legal;

  tfa_decode #(.CODEW(CODEW)) u_dec (
    .pair_code  (in_op),
    .first_code (first_code),
    .second_code(second_code),
    .pair_legal (pair_legal)
  );

  logic [OPW-1:0] st_code [STAGES];
  logic [W-1:0]   st_x    [STAGES];
  logic [W-1:0]   st_y    [STAGES];
  logic [W-1:0]   st_z    [STAGES];

  assign st_code[0] = first_code;
  assign st_code[1] = second_code;

  // chain: stage 0 sees (a,b); stage 1 sees (stage0 output, c)
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign st_x[g] = in_a;
        assign st_y[g] = in_b;
      end else begin : g_tail
        assign st_x[g] = st_z[g-1];
        assign st_y[g] = in_c;
      end
      tfa_opunit #(.W(W)) u_op (
        .code(st_code[g]),
        .x   (st_x[g]),
        .y   (st_y[g]),
        .z   (st_z[g])
      );
    end
  endgenerate

  // named internal events for the assertions
  logic issue_ok;
  logic issue_bad;
  assign issue_ok  = in_valid &&  pair_legal;
  assign issue_bad = in_valid && !pair_legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= issue_ok;
      out_err   <= issue_bad;
      if (issue_ok) out_result <= st_z[STAGES-1];
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ok |=> (out_valid && !out_err));

  assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_bad |=> (out_err && !out_valid));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_ok |=> $stable(out_result));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_err));

  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));

endmodule

// File: tb/tfa_top_test.sv
module tfa_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_op;
  logic [31:0] in_a, in_b, in_c;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] last_res = 32'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tfa_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_result(out_result), .out_err(out_err)
  );

  // 0 = light, 1 = arith, 2 = undefined
  function automatic int kind(input logic [3:0] k);
    if (k <= 4'd4) return 0;
    if (k >= 4'd8 && k <= 4'd12) return 1;
    return 2;
  endfunction

  function automatic bit ok_pair(input logic [7:0] op);
    int k1 = kind(op[7:4]);
    int k2 = kind(op[3:0]);
    if (k1 == 2 || k2 == 2) return 0;
    return !(k1 == 1 && k2 == 1);
  endfunction

  function automatic logic [31:0] model(input logic [3:0] k,
                                       input logic [31:0] x, y);
    logic [63:0] dbl;
    int s;
    s = int'(y & 32'h1f);
    dbl = {x, x};
    case (k)
      4'd1:  return x ^ y;
      4'd2:  return x & y;
      4'd3:  return x + 32'd1;
      4'd4:  return x[7] ? (32'hffffff00 | {24'd0, x[7:0]}) : {24'd0, x[7:0]};
      4'd9:  return x + y;
      4'd10: return x + (~y) + 32'd1;
      4'd11: return (dbl << s) >> 32;
      4'd12: return 32'(dbl >> s);
      default: return x;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one instruction, then check outputs one clock later
  task automatic run(input logic [7:0] op, input logic [31:0] a, b, c,
                     input string req);
    logic [31:0] exp;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_c = c;
    @(negedge clk);
    in_valid = 1'b0;
    if (ok_pair(op)) begin
      exp = model(op[3:0], model(op[7:4], a, b), c);
      chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
      chk({req, " err"}, {31'd0, out_err}, 32'd0);
      chk({req, " result"}, out_result, exp);
      last_res = exp;
    end else begin
      chk({req, " R4 err"}, {31'd0, out_err}, 32'd1);
      chk({req, " R4 valid"}, {31'd0, out_valid}, 32'd0);
      chk({req, " R5 hold"}, out_result, last_res);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7351));
    rst_n = 1'b0; in_valid = 1'b0; in_op = 8'd0;
    in_a = 32'd0; in_b = 32'd0; in_c = 32'd0;
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
    chk("R1 err", {31'd0, out_err}, 32'd0);
    chk("R1 result", out_result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", out_result, 32'd0);

    // directed corner cases
    run(8'h91, 32'h0000_00ff, 32'h0000_0001, 32'h0000_ffff, "R9 add-xor");
    run(8'h2B, 32'hf0f0_1234, 32'hff00_ff00, 32'h0000_0004, "R8 and-rol");
    run(8'h21, 32'h1234_5678, 32'h0f0f_0f0f, 32'hffff_0000, "R6 and-xor");
    run(8'h30, 32'hffff_ffff, 32'hdead_beef, 32'h0, "R6 inc ignores b");
    run(8'h40, 32'h1234_5680, 32'h5555_5555, 32'h0, "R6 sext negative");
    run(8'h40, 32'h8765_437f, 32'haaaa_aaaa, 32'h0, "R6 sext positive");
    run(8'hC1, 32'h8000_0001, 32'hffff_ffe1, 32'h0000_0f00, "R8 ror low5");
    run(8'hB1, 32'h0000_0001, 32'h0000_0000, 32'h1, "R8 rol by 0");
    run(8'h0A, 32'h0000_0005, 32'h1111_1111, 32'h0000_0007, "R7 pass-sub wrap");
    run(8'h99, 32'h1, 32'h2, 32'h3, "R4 arith-arith");
    run(8'h57, 32'h1, 32'h2, 32'h3, "R4 undefined code");
    run(8'h1D, 32'h1, 32'h2, 32'h3, "R3 undefined second");
    run(8'h83, 32'h7fff_ffff, 32'h1, 32'h0, "R3 spass-inc");

    // idle cycles with a busy opcode: nothing must happen
    @(negedge clk);
    in_valid = 1'b0; in_op = 8'h91; in_a = 32'h1234; in_b = 32'h5; in_c = 32'h9;
    @(negedge clk);
    chk("R10 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R10 idle err", {31'd0, out_err}, 32'd0);
    chk("R5 idle hold", out_result, last_res);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      if (($urandom % 8) == 0) op = 8'($urandom);
      else op = {4'($urandom % 13), 4'($urandom % 13)};
      run(op, $urandom, $urandom, $urandom, "R2 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule